// File: doc/BRIEF.md
# Key-Gated Configuration Write Lock

This block sits beside a register file and decides which bus writes may reach it. A dedicated key register watches for two magic 32-bit words. One opens the protected configuration registers for writing. The other closes them again at once. While the block is locked, a write aimed at a protected register is dropped: its write enable never asserts, so the stored contents cannot change. The key register itself is never gated, so refresh words and key words always reach it.

An open session is time-limited. An interval counter is loaded each time the opening word is written. If the closing word does not arrive first, the block re-locks by itself once the interval has run out. Any other word written to the key register, including the refresh word, changes neither the lock state nor the interval countdown. The lock flag is a register, so the lock state a write sees is the state before that cycle's key write. Addresses that are neither the key nor protected are passed through without gating.

Top module: `keylock_top`

## Requirements
- R1: After reset the block is locked: `unlocked` is 0 and every protected write enable stays low.
- R2: A key write of 0x12345678 sets `unlocked` to 1 from the next cycle on. A key write is a strobed write to register index 0 (the `KEY_IDX` default) with all four byte selects set.
- R3: A key write of 0xDEADBEEF clears `unlocked` from the next cycle on.
- R4: With no further key words, `unlocked` stays 1 for exactly `RELOCK_CYCLES` cycles (default 1024) after the opening write, and is 0 after that.
- R5: A new opening write while unlocked restarts the full `RELOCK_CYCLES` interval.
- R6: A key write of 0x5A5A5A5A, or of any value other than the two key words, leaves the lock state and the remaining interval unchanged.
- R7: A write to index 0 carrying one of the key words but with any byte select clear has no effect on the lock state.
- R8: `regWe` for the protected indices 1, 2 and 3 (the `PROT_MASK` default) asserts only for a strobed write to that index while `unlocked` is 1 in the same cycle. It is therefore not asserted in the cycle of the opening write itself.
- R9: `regWe[0]` asserts for every strobed write to index 0, in either lock state.
- R10: For unprotected indices 4 to 7, `regWe` follows the write strobe in either lock state.
- R11: At most one `regWe` bit is high at a time, and none is high without `wrStb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Bus write strobe |
| wrAddr | input | ADDR_W (3) | Register word index of the write |
| wrByteSel | input | 4 | Byte selects of the write |
| wrData | input | 32 | Write data |
| unlocked | output | 1 | Registered lock state, 1 while protected writes are permitted |
| regWe | output | 2**ADDR_W (8) | Per-register gated write enables, one bit per index |

## Verification
The write enables are combinational. They are due in the same cycle that the bus write is presented and depend on the lock flag held in that cycle. The lock flag moves one edge after a key write, and the automatic re-lock lands exactly `RELOCK_CYCLES` cycles after the last opening write. The bench drives one bus cycle per falling edge and queues the enables and the lock flag expected for that cycle. The monitor samples the outputs one nanosecond after that falling edge, before the next rising edge. Every cycle is therefore compared, and so the exact cycle of every lock change and every expiry is checked.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

  localparam int DATA_W = 32;
  localparam int BYTE_N = DATA_W / 8;

  localparam logic [DATA_W-1:0] KEY_OPEN  = 32'h1234_5678;
  localparam logic [DATA_W-1:0] KEY_CLOSE = 32'hDEAD_BEEF;
  localparam logic [DATA_W-1:0] KEY_KICK  = 32'h5A5A_5A5A;

  typedef enum logic {
    LK_SHUT = 1'b0,
    LK_OPEN = 1'b1
  } lockState_t;

  // decoded key-register events, datapath -> control
  typedef struct packed {
    logic openKey;
    logic closeKey;
    logic kickKey;
  } keyEvt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic permit;
  } ctrlStrb_t;

endpackage

// File: rtl/keylock_datapath.sv
module keylock_datapath
  import keylock_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int KEY_IDX = 0,
  parameter logic [(1<<ADDR_W)-1:0] PROT_MASK = 8'b0000_1110
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrStb,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [BYTE_N-1:0]        wrByteSel,
  input  logic [DATA_W-1:0]        wrData,
  input  ctrlStrb_t                ctrlStrb,
  output keyEvt_t                  keyEvt,
  output logic [(1<<ADDR_W)-1:0]   regWe
);

  localparam int NUM_REGS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(KEY_IDX);

  logic keyHit;
  logic keyFull;

  assign keyHit  = wrStb && (wrAddr == KEY_ADDR);
  assign keyFull = keyHit && (&wrByteSel);

  always_comb begin
    keyEvt          = '0;
    keyEvt.openKey  = keyFull && (wrData == KEY_OPEN);
    keyEvt.closeKey = keyFull && (wrData == KEY_CLOSE);
    keyEvt.kickKey  = keyFull && (wrData == KEY_KICK);
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gWe
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    logic hit;
    assign hit = wrStb && (wrAddr == IDX);
    if (g == KEY_IDX) begin : gKey
      assign regWe[g] = hit;
    end else if (PROT_MASK[g]) begin : gProt
      assign regWe[g] = hit && ctrlStrb.permit;
      // R8: a protected enable needs the permit from the control side
      assert_prot_needs_permit_R8: assert property (@(posedge clk) disable iff (!rstN)
        regWe[g] |-> ctrlStrb.permit);
      assert_prot_dropped_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
        (hit && !ctrlStrb.permit) |-> !regWe[g]);
    end else begin : gOpen
      assign regWe[g] = hit;
      assert_open_passes_R10: assert property (@(posedge clk) disable iff (!rstN)
        hit |-> regWe[g]);
    end
  end

  assert_key_never_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    keyHit |-> regWe[KEY_IDX]);

  assert_single_we_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regWe));

  assert_we_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|regWe) |-> wrStb);

endmodule

// File: rtl/keylock_control.sv
module keylock_control
  import keylock_pkg::*;
#(
  parameter int RELOCK_CYCLES = 1024
) (
  input  logic      clk,
  input  logic      rstN,
  input  keyEvt_t   keyEvt,
  output ctrlStrb_t ctrlStrb,
  output logic      unlocked
);

  localparam int CNT_W = (RELOCK_CYCLES > 1) ? $clog2(RELOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RELOCK_CYCLES - 1);

  lockState_t       state;
  logic [CNT_W-1:0] relockCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= LK_SHUT;
      relockCnt <= '0;
    end else if (keyEvt.openKey) begin
      state     <= LK_OPEN;
      relockCnt <= RELOAD;
    end else if (keyEvt.closeKey) begin
      state     <= LK_SHUT;
    end else if (state == LK_OPEN) begin
      if (relockCnt == '0) begin
        state <= LK_SHUT;
      end else begin
        relockCnt <= relockCnt - 1'b1;
      end
    end
  end

  assign unlocked = (state == LK_OPEN);

  always_comb begin
    ctrlStrb        = '0;
    ctrlStrb.permit = unlocked;
  end

  assert_open_unlocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    keyEvt.openKey |=> unlocked);

  assert_only_open_raises_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && !keyEvt.openKey) |=> !unlocked);

  assert_close_locks_R3: assert property (@(posedge clk) disable iff (!rstN)
    keyEvt.closeKey |=> !unlocked);

  assert_expiry_relocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && relockCnt == '0 && !keyEvt.openKey) |=> !unlocked);

  assert_open_restarts_R5: assert property (@(posedge clk) disable iff (!rstN)
    keyEvt.openKey |=> (relockCnt == RELOAD));

  assert_kick_keeps_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    (keyEvt.kickKey && unlocked && relockCnt != '0) |=> unlocked);

  assert_kick_keeps_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (keyEvt.kickKey && unlocked && relockCnt != '0) |=> (relockCnt == $past(relockCnt) - 1'b1));

endmodule

// File: rtl/keylock_top.sv
module keylock_top
  import keylock_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int KEY_IDX = 0,
  parameter logic [(1<<ADDR_W)-1:0] PROT_MASK = 8'b0000_1110,
  parameter int RELOCK_CYCLES = 1024
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrStb,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [3:0]             wrByteSel,
  input  logic [31:0]            wrData,
  output logic                   unlocked,
  output logic [(1<<ADDR_W)-1:0] regWe
);

  keyEvt_t   keyEvt;
  ctrlStrb_t ctrlStrb;

  keylock_datapath #(
    .ADDR_W   (ADDR_W),
    .KEY_IDX  (KEY_IDX),
    .PROT_MASK(PROT_MASK)
  ) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .wrAddr   (wrAddr),
    .wrByteSel(wrByteSel),
    .wrData   (wrData),
    .ctrlStrb (ctrlStrb),
    .keyEvt   (keyEvt),
    .regWe    (regWe)
  );

  keylock_control #(
    .RELOCK_CYCLES(RELOCK_CYCLES)
  ) control_i (
    .clk     (clk),
    .rstN    (rstN),
    .keyEvt  (keyEvt),
    .ctrlStrb(ctrlStrb),
    .unlocked(unlocked)
  );

endmodule

// File: tb/keylock_top_tb_top.sv
module keylock_top_tb_top;

  localparam int RELOCK = 1024;
  localparam logic [7:0] PROT = 8'b0000_1110;

  typedef struct {
    logic [7:0] we;
    logic       unl;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStb = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [3:0] wrByteSel = '0;
  logic [31:0] wrData = '0;
  logic       unlocked;
  logic [7:0] regWe;

  expItem_t   expQ[$];
  int         applied = 0;
  int         miscompares = 0;
  bit         done = 1'b0;

  // reference model of the lock state, built from the requirements
  logic       mUnl = 1'b0;
  int         mLeft = 0;
  string      curTag = "R1";

  always #2 clk = ~clk;

  keylock_top dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .wrAddr   (wrAddr),
    .wrByteSel(wrByteSel),
    .wrData   (wrData),
    .unlocked (unlocked),
    .regWe    (regWe)
  );

  task automatic step(input logic stb, input logic [2:0] addr,
                      input logic [3:0] bsel, input logic [31:0] data);
    expItem_t it;
    logic keyWr;
    @(negedge clk);
    wrStb = stb; wrAddr = addr; wrByteSel = bsel; wrData = data;
    it.we = '0;
    if (stb) begin
      if (addr == 3'd0) it.we[addr] = 1'b1;         // R9
      else if (PROT[addr]) it.we[addr] = mUnl;      // R8
      else it.we[addr] = 1'b1;                      // R10
    end
    it.unl = mUnl;
    it.tag = curTag;
    expQ.push_back(it);
    keyWr = stb && addr == 3'd0 && bsel == 4'hF;    // R7
    if (keyWr && data == 32'h1234_5678) begin        // R2, R5
      mUnl = 1'b1; mLeft = RELOCK;
    end else if (keyWr && data == 32'hDEAD_BEEF) begin // R3
      mUnl = 1'b0;
    end else if (mUnl) begin                         // R4, R6
      mLeft--;
      if (mLeft == 0) mUnl = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 4'h0, 32'h0);
  endtask

  task automatic keyw(input logic [31:0] data);
    step(1'b1, 3'd0, 4'hF, data);
  endtask

  // monitor: compare each queued item 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        applied++;
        if (regWe !== it.we || unlocked !== it.unl) begin
          miscompares++;
          $display("FAIL [%s] regWe=%b unlocked=%b expected regWe=%b unlocked=%b",
                   it.tag, regWe, unlocked, it.we, it.unl);
        end
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    if (!done) begin
      miscompares++;
      $display("FAIL [R4] watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    curTag = "R1";  idle(2);
    curTag = "R8";  step(1'b1, 3'd1, 4'hF, 32'h1);        // protected write, locked
    curTag = "R9";  keyw(32'h0000_0000);                   // key always enabled
    curTag = "R6";  keyw(32'h1111_2222); idle(2);          // other value: no change
    curTag = "R10"; step(1'b1, 3'd5, 4'hF, 32'h3); step(1'b1, 3'd7, 4'h1, 32'h4);
    curTag = "R7";  step(1'b1, 3'd0, 4'b0111, 32'h1234_5678); idle(2);
    curTag = "R7";  step(1'b1, 3'd0, 4'b1110, 32'h1234_5678); idle(1);
    curTag = "R2";  keyw(32'h1234_5678);                   // opening-cycle vector: still locked
    curTag = "R8";  step(1'b1, 3'd2, 4'hF, 32'h5); step(1'b1, 3'd3, 4'hF, 32'h6);
    curTag = "R10"; step(1'b1, 3'd4, 4'hF, 32'h7);
    curTag = "R9";  keyw(32'h0);
    curTag = "R3";  keyw(32'hDEAD_BEEF);
    curTag = "R8";  step(1'b1, 3'd1, 4'hF, 32'h8); step(1'b1, 3'd3, 4'hF, 32'h9);
    curTag = "R7";  keyw(32'h1234_5678);
                    step(1'b1, 3'd0, 4'b0011, 32'hDEAD_BEEF); idle(1);
    curTag = "R4";  idle(RELOCK + 3);                      // full expiry
    curTag = "R8";  step(1'b1, 3'd2, 4'hF, 32'hA);
    curTag = "R5";  keyw(32'h1234_5678); idle(600);
                    keyw(32'h1234_5678); idle(700);
    curTag = "R4";  idle(RELOCK);
    curTag = "R6";  keyw(32'h1234_5678); idle(100);
                    keyw(32'h5A5A_5A5A); keyw(32'hDEAD_BEEE); keyw(32'h5A5A_5A5A);
    curTag = "R4";  idle(RELOCK);
    curTag = "R6";  keyw(32'h5A5A_5A5A); idle(2);          // kick while locked
    curTag = "R11"; step(1'b1, 3'd6, 4'hF, 32'hB); idle(2);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule